// File: doc/BRIEF.md
# Multichannel Audio Frame Deframer with Word Clock

The deframer sits behind a 4B/5B code-group decoder on a multichannel digital audio link. Each clock cycle it may receive one decoded nibble, or a flag saying that the decoder saw a sync symbol pair. It builds 32-bit channel subframes from eight data nibbles. It waits for the subframe that marks channel 0, numbers every subframe after it, and presents the 24-bit sample, the channel flags and the V/U/C/P status bits together with a one-cycle strobe. It also checks parity and flags channel overflow.

The block measures the time between channel-0 subframes in clock cycles. From that it decides whether the link carries normal-length frames (about 20 µs, up to 64 channels) or half-length double-rate frames (about 10 µs, up to 32 channels). It follows a speed change without a reset. From each frame start it also derives an approximate word clock whose high phase is about half a frame long.

Top module: `madi_deframer`

## Requirements
- R1: A subframe is assembled from 8 cycles with nibValid high and nibSync low. The first nibble goes to bits 3:0 and the eighth to bits 31:28. Cycles with nibValid low are ignored. sampleValid pulses for exactly one cycle, in the cycle after the eighth nibble. With it the block outputs sampleData = bits 27:4, chanStatus = bits 31:28 (V at index 0, U at 1, C at 2, P at 3), chanActive = bit 1, abFlag = bit 2 and blockStart = bit 3. These outputs hold until the next strobe.
- R2: A cycle with nibValid and nibSync both high discards any partly assembled subframe. The next data nibble starts a new subframe at bits 3:0. The channel count is left unchanged.
- R3: After reset no strobe is produced until a completed subframe has bit 0 set. Completed subframes before that are dropped.
- R4: A subframe with bit 0 set gets channel 0, and frameStart is driven from bit 0. Every other strobed subframe gets the previous channel number plus one, saturating at 63.
- R5: overflowErr is high with a strobe when the subframe's position in the frame is 64 or more in normal mode, or 32 or more in double-rate mode.
- R6: parityErr is high with a strobe exactly when bits 4 to 31 of the subframe hold an odd number of ones.
- R7: The frame period P is the number of clock cycles between the final nibbles of two successive channel-0 subframes. P < 380 votes for double rate and P >= 380 votes for normal rate.
- R8: doubleRate starts at 0. It changes only when two consecutive measured periods both vote for the other mode, and it switches in the same cycle as the frame-start strobe. A single differing period leaves it unchanged. The mode can switch in either direction without a reset.
- R9: wordClk rises with each frame-start strobe and stays high for max(1, floor(P/2)) cycles, where P is the period just measured (0 at the first frame start).
- R10: During and right after reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nibValid | input | 1 | A decoded symbol is present this cycle |
| nibSync | input | 1 | The present symbol is a sync pair, not data |
| nibData | input | 4 | Decoded data nibble |
| sampleValid | output | 1 | One-cycle strobe for a new subframe |
| sampleData | output | 24 | Audio sample |
| chanNum | output | 6 | Channel number of the subframe |
| chanStatus | output | 4 | V, U, C, P bits (index 0..3) |
| frameStart | output | 1 | Subframe is channel 0 |
| chanActive | output | 1 | Channel active flag |
| abFlag | output | 1 | A/B preamble flag |
| blockStart | output | 1 | Block start flag |
| parityErr | output | 1 | Parity error on this subframe |
| overflowErr | output | 1 | Channel position beyond the mode's limit |
| doubleRate | output | 1 | Double-rate frame mode selected |
| wordClk | output | 1 | Approximate word clock |

## Verification
Random subframe words, with random idle cycles between nibbles, separate correct bit packing from simple nibble counting, and their random parity exercises both values of the parity flag. Frames of 56, 64 and 66 channels at normal rate, and of 32 and 34 channels at double rate, separate correct numbering from saturation and from the mode-dependent overflow limit. Periods of exactly 379 and 380 cycles pin down the threshold. A lone long frame inside a double-rate run shows that a single vote does not change the mode. Sync symbols inside a subframe show that the alignment restarts while the channel count carries on.

// File: rtl/madi_pkg.sv
package madi_pkg;
  // Strobes from the control to the datapath.
  typedef struct packed {
    logic shiftEn;   // accept a data nibble
    logic emit;      // publish the completed subframe
  } dfrStrobe_t;
endpackage

// File: rtl/madi_dfr_ctrl.sv
module madi_dfr_ctrl
  import madi_pkg::*;
#(
  parameter int NIBS_PER_SUB = 8,
  parameter int MAX_CH       = 64,
  parameter int PERIOD_W     = 12,
  parameter int DBL_THRESH   = 380
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      nibValid,
  input  logic                      nibSync,
  input  logic                      wordBit0,
  output dfrStrobe_t                strobe,
  output logic [$clog2(MAX_CH)-1:0] chanNum,
  output logic                      overflowErr,
  output logic                      doubleRate,
  output logic                      wordClk
);
  localparam int NC_W  = $clog2(NIBS_PER_SUB);
  localparam int CH_W  = $clog2(MAX_CH);
  localparam int IDX_W = CH_W + 1;
  localparam logic [IDX_W-1:0]    FULL_LIM = IDX_W'(MAX_CH);
  localparam logic [IDX_W-1:0]    HALF_LIM = IDX_W'(MAX_CH / 2);
  localparam logic [NC_W-1:0]     LAST_NIB = NC_W'(NIBS_PER_SUB - 1);
  localparam logic [PERIOD_W-1:0] P_MAX    = {PERIOD_W{1'b1}};
  localparam logic [PERIOD_W-1:0] THRESH   = PERIOD_W'(DBL_THRESH);

  logic [NC_W-1:0]     nibCnt;
  logic                locked;
  logic [IDX_W-1:0]    nextIdx, idx, chanLimit;
  logic [PERIOD_W-1:0] periodCnt, measured, halfP, hiInit, wcLeft;
  logic                havePrev, haveLast, lastCand, cand;
  logic                shiftEn, complete, startEv, emit;

  // nibble alignment
  assign shiftEn  = nibValid & ~nibSync;
  assign complete = shiftEn & (nibCnt == LAST_NIB);
  assign startEv  = complete & wordBit0;
  assign emit     = complete & (locked | wordBit0);
  assign strobe   = '{shiftEn: shiftEn, emit: emit};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nibCnt <= '0;
      locked <= 1'b0;
    end else begin
      if (nibValid && nibSync) nibCnt <= '0;
      else if (shiftEn)        nibCnt <= complete ? '0 : nibCnt + 1'b1;
      if (startEv) locked <= 1'b1;
    end
  end

  // channel numbering and overflow
  assign idx       = wordBit0 ? '0 : nextIdx;
  assign chanLimit = doubleRate ? HALF_LIM : FULL_LIM;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nextIdx     <= '0;
      chanNum     <= '0;
      overflowErr <= 1'b0;
    end else if (emit) begin
      nextIdx     <= (idx >= FULL_LIM) ? FULL_LIM : idx + 1'b1;
      chanNum     <= (idx >= FULL_LIM) ? {CH_W{1'b1}} : idx[CH_W-1:0];
      overflowErr <= (idx >= chanLimit);
    end
  end

  // frame period measurement
  assign measured = havePrev ? periodCnt : '0;
  assign cand     = (measured < THRESH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      periodCnt <= '0;
      havePrev  <= 1'b0;
    end else if (startEv) begin
      periodCnt <= PERIOD_W'(1);
      havePrev  <= 1'b1;
    end else if (havePrev && periodCnt != P_MAX) begin
      periodCnt <= periodCnt + 1'b1;
    end
  end

  // rate decision with two-frame agreement
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      doubleRate <= 1'b0;
      lastCand   <= 1'b0;
      haveLast   <= 1'b0;
    end else if (startEv && havePrev) begin
      if (cand != doubleRate && haveLast && lastCand == cand) doubleRate <= cand;
      lastCand <= cand;
      haveLast <= 1'b1;
    end
  end

  // word clock: high for half the measured period
  assign halfP  = measured >> 1;
  assign hiInit = (halfP > PERIOD_W'(1)) ? halfP - 1'b1 : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wordClk <= 1'b0;
      wcLeft  <= '0;
    end else if (startEv) begin
      wordClk <= 1'b1;
      wcLeft  <= hiInit;
    end else if (wordClk) begin
      if (wcLeft == '0) wordClk <= 1'b0;
      else              wcLeft  <= wcLeft - 1'b1;
    end
  end
endmodule

// File: rtl/madi_dfr_datapath.sv
module madi_dfr_datapath
  import madi_pkg::*;
#(
  parameter int NIBS_PER_SUB = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  nibData,
  input  dfrStrobe_t  strobe,
  output logic        wordBit0,
  output logic        sampleValid,
  output logic [23:0] sampleData,
  output logic [3:0]  chanStatus,
  output logic        frameStart,
  output logic        chanActive,
  output logic        abFlag,
  output logic        blockStart,
  output logic        parityErr
);
  localparam int NIB_W  = 4;
  localparam int SUB_W  = NIBS_PER_SUB * NIB_W;
  localparam int SR_W   = SUB_W - NIB_W;
  localparam int AUD_LO = 4;
  localparam int AUD_HI = 27;
  localparam int ST_LO  = 28;

  logic [SR_W-1:0]  shReg;
  logic [SUB_W-1:0] fullWord;

  // newest nibble enters at the top; the first ends up at the bottom
  assign fullWord = {nibData, shReg};
  assign wordBit0 = shReg[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shReg       <= '0;
      sampleValid <= 1'b0;
      sampleData  <= '0;
      chanStatus  <= '0;
      frameStart  <= 1'b0;
      chanActive  <= 1'b0;
      abFlag      <= 1'b0;
      blockStart  <= 1'b0;
      parityErr   <= 1'b0;
    end else begin
      if (strobe.shiftEn) shReg <= fullWord[SUB_W-1:NIB_W];
      sampleValid <= strobe.emit;
      if (strobe.emit) begin
        frameStart <= fullWord[0];
        chanActive <= fullWord[1];
        abFlag     <= fullWord[2];
        blockStart <= fullWord[3];
        sampleData <= fullWord[AUD_HI:AUD_LO];
        chanStatus <= fullWord[SUB_W-1:ST_LO];
        parityErr  <= ^fullWord[SUB_W-1:AUD_LO];
      end
    end
  end
endmodule

// File: rtl/madi_deframer.sv
module madi_deframer
  import madi_pkg::*;
#(
  parameter int NIBS_PER_SUB = 8,
  parameter int MAX_CH       = 64,
  parameter int PERIOD_W     = 12,
  parameter int DBL_THRESH   = 380
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      nibValid,
  input  logic                      nibSync,
  input  logic [3:0]                nibData,
  output logic                      sampleValid,
  output logic [23:0]               sampleData,
  output logic [$clog2(MAX_CH)-1:0] chanNum,
  output logic [3:0]                chanStatus,
  output logic                      frameStart,
  output logic                      chanActive,
  output logic                      abFlag,
  output logic                      blockStart,
  output logic                      parityErr,
  output logic                      overflowErr,
  output logic                      doubleRate,
  output logic                      wordClk
);
  dfrStrobe_t strobe;
  logic       wordBit0;

  madi_dfr_ctrl #(
    .NIBS_PER_SUB(NIBS_PER_SUB), .MAX_CH(MAX_CH),
    .PERIOD_W(PERIOD_W), .DBL_THRESH(DBL_THRESH)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .nibValid(nibValid), .nibSync(nibSync),
    .wordBit0(wordBit0), .strobe(strobe), .chanNum(chanNum),
    .overflowErr(overflowErr), .doubleRate(doubleRate), .wordClk(wordClk)
  );

  madi_dfr_datapath #(.NIBS_PER_SUB(NIBS_PER_SUB)) u_dp (
    .clk(clk), .rst_n(rst_n), .nibData(nibData), .strobe(strobe),
    .wordBit0(wordBit0), .sampleValid(sampleValid), .sampleData(sampleData),
    .chanStatus(chanStatus), .frameStart(frameStart), .chanActive(chanActive),
    .abFlag(abFlag), .blockStart(blockStart), .parityErr(parityErr)
  );
endmodule

// File: rtl/madi_deframer_chk.sv
module madi_deframer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sampleValid,
  input logic [23:0] sampleData,
  input logic [5:0]  chanNum,
  input logic [3:0]  chanStatus,
  input logic        frameStart,
  input logic        parityErr,
  input logic        overflowErr,
  input logic        doubleRate,
  input logic        wordClk
);
  logic [5:0] lastChan;
  logic       seenStrobe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lastChan   <= '0;
      seenStrobe <= 1'b0;
    end else if (sampleValid) begin
      lastChan   <= chanNum;
      seenStrobe <= 1'b1;
    end
  end

  // R1: strobes are never back to back
  a_r1_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sampleValid |=> !sampleValid);

  // R4: the frame-start subframe is channel 0
  a_r4_start_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sampleValid && frameStart) |-> chanNum == 6'd0);

  // R4: other subframes follow the previous channel number
  a_r4_chan_step: assert property (@(posedge clk) disable iff (!rst_n)
    (sampleValid && !frameStart && seenStrobe) |->
      chanNum == ((lastChan == 6'd63) ? 6'd63 : lastChan + 6'd1));

  // R5: channels below 32 never overflow
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (sampleValid && chanNum < 6'd32) |-> !overflowErr);

  // R6: parity flag matches the published fields
  a_r6_parity: assert property (@(posedge clk) disable iff (!rst_n)
    sampleValid |-> parityErr == ^{chanStatus, sampleData});

  // R8: mode changes only with a frame-start strobe
  a_r8_mode_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(doubleRate) |-> (sampleValid && frameStart));

  // R9: word clock rises only at a frame start
  a_r9_wc_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wordClk) |-> (sampleValid && frameStart));
endmodule

bind madi_deframer madi_deframer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid), .sampleData(sampleData),
  .chanNum(chanNum), .chanStatus(chanStatus), .frameStart(frameStart),
  .parityErr(parityErr), .overflowErr(overflowErr), .doubleRate(doubleRate),
  .wordClk(wordClk)
);

// File: tb/sim_madi_deframer.sv
`timescale 1ns/1ps
module sim_madi_deframer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nibValid = 1'b0, nibSync = 1'b0;
  logic [3:0] nibData = '0;
  logic sampleValid, frameStart, chanActive, abFlag, blockStart;
  logic parityErr, overflowErr, doubleRate, wordClk;
  logic [23:0] sampleData;
  logic [5:0]  chanNum;
  logic [3:0]  chanStatus;

  always #2.5 clk = ~clk;

  madi_deframer u0 (
    .clk(clk), .rst_n(rst_n), .nibValid(nibValid), .nibSync(nibSync),
    .nibData(nibData), .sampleValid(sampleValid), .sampleData(sampleData),
    .chanNum(chanNum), .chanStatus(chanStatus), .frameStart(frameStart),
    .chanActive(chanActive), .abFlag(abFlag), .blockStart(blockStart),
    .parityErr(parityErr), .overflowErr(overflowErr),
    .doubleRate(doubleRate), .wordClk(wordClk)
  );

  int nChecks = 0, nFail = 0;
  bit done = 0;

  // expectation model
  int    edgeNo = 0, lastEdge = 0, nextIdx = 0, wcLeft = 0, idlePct = 0;
  bit    locked = 0, havePrev = 0, haveLast = 0, lastCand = 0;
  bit    expValid = 0, expDbl = 0, expWc = 0, expOvf = 0;
  int    expChan = 0;
  logic [31:0] expWord = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit oddParity(input logic [31:0] w);
    return ^w[31:4];
  endfunction

  task automatic checkNow();
    chk("R1 R3 sampleValid", 32'(sampleValid), 32'(expValid));
    chk("R8 doubleRate", 32'(doubleRate), 32'(expDbl));
    chk("R9 wordClk", 32'(wordClk), 32'(expWc));
    if (expValid) begin
      chk("R1 sampleData", 32'(sampleData), 32'(expWord[27:4]));
      chk("R1 chanStatus", 32'(chanStatus), 32'(expWord[31:28]));
      chk("R1 flags", 32'({blockStart, abFlag, chanActive}), 32'(expWord[3:1]));
      chk("R4 frameStart", 32'(frameStart), 32'(expWord[0]));
      chk("R4 chanNum", 32'(chanNum), 32'(expChan));
      chk("R5 overflowErr", 32'(overflowErr), 32'(expOvf));
      chk("R6 parityErr", 32'(parityErr), 32'(oddParity(expWord)));
    end
  endtask

  // one clock: check the previous edge's result, drive, predict this edge
  task automatic step(input logic v, input logic s, input logic [3:0] d,
                      input bit last, input logic [31:0] w);
    bit ev, em, cand;
    int p, h, idx;
    @(negedge clk);
    checkNow();
    nibValid = v; nibSync = s; nibData = d;
    edgeNo++;
    ev = last && w[0];
    em = last && (locked || w[0]);
    expValid = em;
    p = (ev && havePrev) ? edgeNo - lastEdge : 0;
    if (ev) begin
      h = (p / 2 > 1) ? p / 2 : 1;
      expWc = 1; wcLeft = h - 1;
    end else if (expWc) begin
      if (wcLeft == 0) expWc = 0; else wcLeft--;
    end
    if (em) begin
      idx = w[0] ? 0 : nextIdx;
      expOvf  = idx >= (expDbl ? 32 : 64);
      expChan = (idx > 63) ? 63 : idx;
      nextIdx = (idx >= 64) ? 64 : idx + 1;
      expWord = w;
    end
    if (ev) begin
      if (havePrev) begin
        cand = (p < 380);
        if (cand != expDbl && haveLast && lastCand == cand) expDbl = cand;
        lastCand = cand; haveLast = 1;
      end
      havePrev = 1; lastEdge = edgeNo; locked = 1;
    end
  endtask

  task automatic sendSub(input logic [31:0] w);
    for (int i = 0; i < 8; i++) begin
      if (idlePct > 0 && ($urandom % 100) < idlePct)
        step(1'b0, 1'b0, 4'($urandom), 0, '0);
      step(1'b1, 1'b0, w[4*i +: 4], i == 7, w);
    end
  endtask

  task automatic sendFrame(input int nCh, input int gap, input bit syncFill);
    logic [31:0] w;
    for (int c = 0; c < nCh; c++) begin
      w = $urandom;
      w[0] = (c == 0);
      sendSub(w);
    end
    for (int g = 0; g < gap; g++)
      step(syncFill, syncFill, 4'($urandom), 0, '0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    // R10: reset state
    chk("R10 sampleValid", 32'(sampleValid), 0);
    chk("R10 wordClk", 32'(wordClk), 0);
    chk("R10 doubleRate", 32'(doubleRate), 0);
    chk("R10 overflowErr", 32'(overflowErr), 0);
    chk("R10 chanNum", 32'(chanNum), 0);
    rst_n = 1'b1;

    // R3: subframes before the first channel-0 marker are dropped
    for (int k = 0; k < 3; k++) sendSub($urandom & 32'hFFFF_FFFE);

    // R2: partial subframe discarded by sync
    step(1'b1, 1'b0, 4'h1, 0, '0);
    step(1'b1, 1'b0, 4'h7, 0, '0);
    step(1'b1, 1'b0, 4'h3, 0, '0);
    step(1'b1, 1'b1, 4'h0, 0, '0);
    sendSub(32'hA5C3_7E1B);   // bit0 set: frame start, aligned after sync
    step(1'b0, 1'b0, 4'h0, 0, '0);
    chk("R2 aligned word after sync", 32'({chanStatus, sampleData, blockStart, abFlag, chanActive, frameStart}), 32'hA5C3_7E1B);
    sendSub(32'h0000_0012);
    step(1'b1, 1'b0, 4'hF, 0, '0);
    step(1'b1, 1'b1, 4'h0, 0, '0);
    sendSub(32'h1234_5670);
    step(1'b0, 1'b0, 4'h0, 0, '0);
    chk("R2 channel count kept across sync", 32'(chanNum), 2);

    // normal frames with random idles
    idlePct = 5;
    for (int f = 0; f < 3; f++) sendFrame(56, 40, f[0]);
    idlePct = 0;
    sendFrame(64, 8, 1'b1);
    sendFrame(66, 8, 1'b0);   // R5: overflow at 64, 65
    sendFrame(56, 20, 1'b0);
    chk("R8 still normal", 32'(doubleRate), 0);

    // R7: period 379 -> double rate after two agreeing frames
    for (int f = 0; f < 4; f++) sendFrame(32, 123, 1'b1);
    chk("R7 379-cycle period selects double rate", 32'(doubleRate), 1);
    sendFrame(34, 10, 1'b0);  // R5: overflow at 32, 33 in double rate
    // R8: one long frame does not switch back
    sendFrame(56, 0, 1'b0);
    sendFrame(32, 20, 1'b0);
    sendFrame(32, 20, 1'b0);
    chk("R8 single long frame ignored", 32'(doubleRate), 1);
    // R7: period 380 -> back to normal
    for (int f = 0; f < 4; f++) sendFrame(32, 124, 1'b0);
    chk("R7 380-cycle period selects normal", 32'(doubleRate), 0);

    // random mix of speeds
    idlePct = 3;
    for (int f = 0; f < 24; f++) begin
      case ($urandom % 3)
        0: sendFrame(32, 10 + int'($urandom % 40), $urandom % 2 == 0);
        1: sendFrame(56, int'($urandom % 60), $urandom % 2 == 0);
        default: sendFrame(64 + int'($urandom % 3), int'($urandom % 20), 1'b0);
      endcase
    end
    idlePct = 0;
    sendFrame(1, 5, 1'b0);
    step(1'b0, 1'b0, 4'h0, 0, '0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end
endmodule